// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a byte-wide serial EEPROM that sits on a two-wire bus. The system clock oversamples the bus clock and data lines, finds START and STOP conditions, and checks each device-select byte against a fixed prefix and three strap inputs. That lets up to eight copies share one bus. After a select byte for writing, two word-address bytes set an internal pointer. Data bytes that follow are gathered in a one-page buffer. After a select byte for reading, the block returns bytes from the pointer and advances it after each byte.

A STOP that ends a write hands the gathered bytes to a self-timed write cycle. During that cycle the bytes are committed into a plain register array, and the block ignores its own device address so that a controller can poll for completion. A write-protect input keeps data bytes out of the buffer while they are still acknowledged. The data line is open-drain: the single output only asks for the line to be pulled low.

Top module: `eep_target`

## Requirements
- R1: After reset, and whenever no acknowledge or data bit is owed, `sda_pull_o` is 0, so the block releases the data line and never drives it high.
- R2: A device-select byte is acknowledged (line pulled low on the ninth clock) only when its bits 7..4 equal 1010 and its bits 3..1 equal `strap_i`. Bit 0 selects reading (1) or writing (0). Any other select byte gets no acknowledge.
- R3: A write select byte is followed by two word-address bytes, the high byte first. Address bits at and above ADDR_W are ignored.
- R4: Each data byte of a write is acknowledged and placed at the pointer. The low 5 pointer bits then increment and wrap inside the 32-byte page while the page bits stay fixed. From 1 to 32 bytes may be written in one transaction.
- R5: The STOP that ends a write with buffered bytes starts a write cycle of WRITE_CLKS system clocks. The bytes reach the array during this cycle. While it runs, the device-select byte is not acknowledged, and afterwards it is acknowledged again.
- R6: A data byte received while `wp_i` is 1 is acknowledged but not buffered, so the array keeps its contents. When no byte was buffered, the STOP starts no write cycle.
- R7: Reads return the byte at the pointer and advance it by one after each byte, across page boundaries and from the last location back to 0. A random read uses a write select byte and an address, then a repeated START with a read select byte. A current read needs no address. The read ends when the controller does not acknowledge.
- R8: SDA is sampled on rising SCL edges, and `sda_pull_o` changes only while SCL is low, so the block's output is stable throughout every SCL high phase.
- R9: A write that carries only the address and then a STOP starts no write cycle. It leaves the pointer at that address for a following current read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired, includes own pull) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device address straps |
| wp_i | input | 1 | Write protect, 1 blocks array updates |

## Verification
The block's reply to an SCL falling edge (a new data bit or an acknowledge pull) shows on `sda_pull_o` about three system clocks later: two synchronizer stages plus the output register. The bench therefore changes SCL only after five quiet clocks and reads the data line in the middle and at the end of each high phase, where the reply is long settled.

A committed write becomes readable only after the STOP plus WRITE_CLKS clocks. Completion is polled right after the STOP, which is well inside the cycle, so that poll must get no acknowledge. Reads of new data then wait beyond the full cycle before they start.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;
  typedef enum logic [1:0] {PH_DEV, PH_AHI, PH_ALO, PH_DATA} byte_ph_e;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES:0] scl_sh;
  logic [SYNC_STAGES:0] sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_prev  = scl_sh[SYNC_STAGES];
  assign sda_prev  = sda_sh[SYNC_STAGES];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eep_page_buffer.sv
module eep_page_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 we,
  input  logic [PAGE_W-1:0]    widx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [PAGE_W-1:0]    ridx,
  output logic [DATA_W-1:0]    rdata,
  output logic [(1<<PAGE_W)-1:0] valid,
  output logic                 any
);
  localparam int PAGE = 1 << PAGE_W;

  logic [DATA_W-1:0] slot [PAGE];

  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == PAGE_W'(i)) slot[i] <= wdata;
    end
    always_ff @(posedge clk) begin
      if (rst || clr) valid[i] <= 1'b0;
      else if (we && widx == PAGE_W'(i)) valid[i] <= 1'b1;
    end
  end

  assign rdata = slot[ridx];
  assign any   = |valid;

  AST_NO_FILL_ON_CLEAR: assert property (@(posedge clk) disable iff (rst) !(clr && we)); // R4
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_target.sv
module eep_target import eep_pkg::*; #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int WRITE_CLKS  = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int WCW  = $clog2(WRITE_CLKS + 1);
  localparam logic [WCW-1:0] WC_LAST = WCW'(WRITE_CLKS - 1);
  localparam logic [WCW-1:0] WC_PAGE = WCW'(PAGE);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  bus_st_e  st;
  byte_ph_e ph;
  logic [3:0] bitcnt;
  logic [7:0] sh, hi_q, rd_data, buf_rdata;
  logic rw_q, more_q, busy_q;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [WCW-1:0] wcnt;
  logic [15:0] full_addr;
  logic byte_done, dev_match, buf_we, buf_clr, buf_any, mem_we;
  logic [PAGE-1:0] buf_valid;
  logic [PAGE_W-1:0] buf_ridx;

  eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign full_addr = {hi_q, sh};
  assign byte_done = (st == ST_RX) && !start_det && !stop_det && scl_fall && (bitcnt == 4'd8);
  assign dev_match = (sh[7:4] == DEV_PREFIX) && (sh[3:1] == strap_i) && !busy_q;
  assign buf_we    = byte_done && (ph == PH_DATA) && !wp_i;
  assign buf_clr   = (byte_done && (ph == PH_ALO)) || (busy_q && (wcnt == WC_LAST));
  assign buf_ridx  = wcnt[PAGE_W-1:0];
  assign mem_we    = busy_q && (wcnt < WC_PAGE) && buf_valid[buf_ridx];

  eep_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(8)) u_pagebuf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(cur[PAGE_W-1:0]),
    .wdata(sh), .ridx(buf_ridx), .rdata(buf_rdata), .valid(buf_valid), .any(buf_any)
  );

  eep_store #(.ADDR_W(ADDR_W), .DATA_W(8)) u_store (
    .clk(clk), .we(mem_we), .waddr({page_q, buf_ridx}), .wdata(buf_rdata),
    .raddr(cur), .rdata(rd_data)
  );

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      ph <= PH_DEV;
      bitcnt <= '0;
      sh <= '0;
      hi_q <= '0;
      rw_q <= 1'b0;
      more_q <= 1'b0;
      sda_pull_o <= 1'b0;
      cur <= '0;
      page_q <= '0;
    end else if (start_det) begin
      st <= ST_RX;
      ph <= PH_DEV;
      bitcnt <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            sh <= {sh[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            case (ph)
              PH_DEV: begin
                if (dev_match) begin
                  rw_q <= sh[0];
                  sda_pull_o <= 1'b1;
                  st <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_AHI: begin
                hi_q <= sh;
                sda_pull_o <= 1'b1;
                st <= ST_ACK;
              end
              PH_ALO: begin
                cur <= full_addr[ADDR_W-1:0];
                page_q <= full_addr[ADDR_W-1:PAGE_W];
                sda_pull_o <= 1'b1;
                st <= ST_ACK;
              end
              default: begin
                cur <= {cur[ADDR_W-1:PAGE_W], cur[PAGE_W-1:0] + 1'b1};
                sda_pull_o <= 1'b1;
                st <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (ph == PH_DEV && rw_q) begin
              sh <= rd_data;
              sda_pull_o <= ~rd_data[7];
              bitcnt <= '0;
              cur <= cur + 1'b1;
              st <= ST_TX;
            end else begin
              sda_pull_o <= 1'b0;
              st <= ST_RX;
              case (ph)
                PH_DEV:  ph <= PH_AHI;
                PH_AHI:  ph <= PH_ALO;
                default: ph <= PH_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_pull_o <= 1'b0;
              st <= ST_MACK;
            end else begin
              sh <= {sh[6:0], 1'b0};
              sda_pull_o <= ~sh[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            more_q <= ~sda_lvl;
          end else if (scl_fall) begin
            if (more_q) begin
              sh <= rd_data;
              sda_pull_o <= ~rd_data[7];
              bitcnt <= '0;
              cur <= cur + 1'b1;
              st <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // self-timed write cycle: commit buffer in the first PAGE clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wcnt <= '0;
    end else if (busy_q) begin
      if (wcnt == WC_LAST) busy_q <= 1'b0;
      wcnt <= wcnt + 1'b1;
    end else if (stop_det && buf_any) begin
      busy_q <= 1'b1;
      wcnt <= '0;
    end
  end

  AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_lvl); // R8
  AST_NO_SELECT_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && ph == PH_DEV) |-> !busy_q); // R5
  AST_CYCLE_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(buf_any)); // R6
  AST_LOAD_ADVANCES_PTR: assert property (@(posedge clk) disable iff (rst)
    ($past(st) != ST_TX && st == ST_TX) |-> (cur == $past(cur) + 1'b1)); // R7
endmodule

// File: tb/eep_target_test.sv
module eep_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WCLK = 400;
  localparam int Q = 5;
  localparam int WD_CYCLES = 195000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_scl = 1'b1;
  logic tb_pull = 1'b0;
  logic wp = 1'b0;
  logic dut_pull;
  logic sda_line;

  int nchk = 0;
  int nerr = 0;
  int r8_bad = 0;
  int ref_cur = 0;
  logic [7:0] ref_mem [DEPTH];
  bit ref_ok [DEPTH];
  logic [7:0] wdat [32];
  logic [7:0] rdat [32];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = ~(tb_pull | dut_pull);

  eep_target #(.ADDR_W(ADDR_W), .PAGE_W(5), .WRITE_CLKS(WCLK), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_i(tb_scl), .sda_i(sda_line), .sda_pull_o(dut_pull),
    .strap_i(STRAP), .wp_i(wp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_pull = 1'b0; wq();
    tb_scl = 1'b1; wq();
    tb_pull = 1'b1; wq();
    tb_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    tb_pull = 1'b1; wq();
    tb_scl = 1'b1; wq();
    tb_pull = 1'b0; wq();
  endtask

  task automatic put_bit(input logic b);
    tb_pull = ~b; wq();
    tb_scl = 1'b1; wq(); wq();
    tb_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    tb_pull = 1'b0; wq();
    tb_scl = 1'b1; wq();
    b = sda_line; wq();
    if (sda_line !== b) r8_bad++;
    tb_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic poll(output logic a);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    bus_stop();
  endtask

  task automatic wait_write();
    repeat (WCLK + 20) @(negedge clk);
  endtask

  task automatic send_addr(input int addr, input bit noise, inout int nak);
    logic a;
    logic [7:0] hi;
    hi = 8'((addr >> 8) & 8'h0F);
    if (noise) hi = hi | 8'hA0;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); if (!a) nak++;
    send_byte(hi, a); if (!a) nak++;
    send_byte(8'(addr), a); if (!a) nak++;
  endtask

  task automatic do_write(input int addr, input int n, input bit noise);
    logic a;
    int nak = 0;
    send_addr(addr, noise, nak);
    for (int k = 0; k < n; k++) begin
      send_byte(wdat[k], a);
      if (!a) nak++;
    end
    bus_stop();
    check(nak == 0, "R4 write bytes acknowledged", nak, 0);
    if (!wp) begin
      for (int k = 0; k < n; k++) begin
        int ad;
        ad = (addr & ~31) | ((addr + k) & 31);
        ref_mem[ad] = wdat[k];
        ref_ok[ad] = 1'b1;
      end
    end
    ref_cur = (addr & ~31) | ((addr + n) & 31);
  endtask

  task automatic do_read(input int addr, input int n, input bit random, input string req);
    logic a;
    int nak = 0;
    int base;
    if (random) begin
      send_addr(addr, 1'b0, nak);
      base = addr;
    end else begin
      base = ref_cur;
    end
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a); if (!a) nak++;
    for (int k = 0; k < n; k++) recv_byte(rdat[k], k != n - 1);
    bus_stop();
    check(nak == 0, "R7 read select acknowledged", nak, 0);
    for (int k = 0; k < n; k++) begin
      int ad;
      ad = (base + k) % DEPTH;
      if (ref_ok[ad]) check(rdat[k] === ref_mem[ad], req, int'(rdat[k]), int'(ref_mem[ad]));
    end
    ref_cur = (base + n) % DEPTH;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic a;
    int nak;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wq();
    check(dut_pull == 1'b0, "R1 released after reset", int'(dut_pull), 0);
    check(sda_line == 1'b1, "R1 line idle high", int'(sda_line), 1);

    // R2: select decoding
    bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, a); bus_stop();
    check(!a, "R2 wrong strap not acknowledged", int'(a), 0);
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a); bus_stop();
    check(!a, "R2 wrong prefix not acknowledged", int'(a), 0);
    check(dut_pull == 1'b0, "R1 released after mismatch", int'(dut_pull), 0);
    poll(a);
    check(a, "R2 matching select acknowledged", int'(a), 1);

    // R5: partial write then busy window
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
    do_write(12'h0A3, 4, 1'b0);
    poll(a);
    check(!a, "R5 select ignored during write cycle", int'(a), 0);
    wait_write();
    poll(a);
    check(a, "R5 select acknowledged after write cycle", int'(a), 1);
    do_read(12'h0A3, 4, 1'b1, "R7 random read");

    // R4: in-page wrap and a full page
    for (int k = 0; k < 4; k++) wdat[k] = 8'($urandom);
    do_write(12'h15E, 4, 1'b0);
    wait_write();
    do_read(12'h140, 2, 1'b1, "R4 in-page wrap low bytes");
    do_read(12'h15E, 2, 1'b1, "R4 in-page wrap high bytes");
    for (int k = 0; k < 32; k++) wdat[k] = 8'($urandom);
    do_write(12'h160, 32, 1'b0);
    wait_write();
    do_read(12'h15E, 4, 1'b1, "R7 sequential read across page");

    // R3: upper address bits ignored
    wdat[0] = 8'h5A; wdat[1] = 8'hC3;
    do_write(12'h2C5, 2, 1'b1);
    wait_write();
    do_read(12'h2C5, 2, 1'b1, "R3 upper address bits ignored");

    // R7: top-to-zero wrap and current read
    wdat[0] = 8'h9E;
    do_write(12'hFFF, 1, 1'b0);
    wait_write();
    wdat[0] = 8'h01; wdat[1] = 8'h02;
    do_write(12'h000, 2, 1'b0);
    wait_write();
    do_read(12'hFFF, 3, 1'b1, "R7 wrap from last location");
    do_read(12'hFFF, 2, 1'b1, "R7 wrap two bytes");
    do_read(0, 1, 1'b0, "R7 current read");

    // R9: address-only write
    nak = 0;
    send_addr(12'h0A4, 1'b0, nak);
    bus_stop();
    check(nak == 0, "R9 address bytes acknowledged", nak, 0);
    poll(a);
    check(a, "R9 no write cycle after address only", int'(a), 1);
    ref_cur = 12'h0A4;
    do_read(0, 2, 1'b0, "R9 current read from set address");

    // R6: write protect
    wp = 1'b1;
    wdat[0] = 8'hF0; wdat[1] = 8'hF1; wdat[2] = 8'hF2;
    do_write(12'h0A3, 3, 1'b0);
    poll(a);
    check(a, "R6 no write cycle when protected", int'(a), 1);
    wp = 1'b0;
    do_read(12'h0A3, 3, 1'b1, "R6 protected bytes unchanged");

    // R4: constrained random page writes
    for (int it = 0; it < 5; it++) begin
      int pg, off, n;
      pg = int'($urandom % 128);
      off = int'($urandom % 32);
      n = 1 + int'($urandom % 32);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      do_write(pg * 32 + off, n, 1'b0);
      wait_write();
      do_read(pg * 32, 32, 1'b1, "R4 random page contents");
    end

    check(r8_bad == 0, "R8 output stable while SCL high", r8_bad, 0);
    check(dut_pull == 1'b0, "R1 released at end", int'(dut_pull), 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule